// File: doc/BRIEF.md
# Emulated Card Reader Preread Buffer

This controller sits between a physical punched-card reader and a host that sees an emulated reader with a one-card preread station. The station is a column store that always holds the next card ahead of the host. A host feed request hands the held card to the host column by column. While that card drains, the block asks the physical reader for the next card and stores its columns behind it. Readiness and station occupancy are decided only at fixed sample points. The live column count falls to empty during every feed, so it cannot be trusted in the middle of one.

Errors follow the rules of the emulated machine. A feed check on the physical side stops the block at once and drops ready. A read check arrives in the middle of a card and leaves it short. The block fills the rest of that card with blank columns and marks it. The fault is reported on the next feed, which is the one that would carry the damaged card out of the station. When the hopper runs dry, ready drops and the held card stays put. The operator start button then enters last-card mode, which releases that final card. The non-process runout button empties the station and clears every error.

Top module: `card_feed_buffer`

## Requirements
- R1: After reset, `status`, `sense_word` and `phys_feed` are all zero. The status bits are: bit0 ready, bit1 last-card, bit2 feed check, bit3 read check, bit4 preread station full.
- R2: Start with the station empty and the hopper loaded raises `phys_feed` for exactly one cycle. Once the card's columns are captured, `status` reads 5'b10001.
- R3: A feed cycle hands the host exactly the stored columns, in capture order. `host_col_valid` is high for 80 accepted pops and is low afterwards.
- R4: A feed from the ready state issues one `phys_feed` pulse in the cycle after the request. The incoming card is stored behind the one being drained. When both are finished, the block returns to ready with the station full.
- R5: The station-full bit keeps its pre-feed value throughout a feed cycle and changes only at the sample point at the end of the feed.
- R6: A read check pads the card to 80 columns with the value zero, and the block stays ready. The next feed request does not feed. It moves to the error state with `status` 5'b11000.
- R7: A feed check during run-in or during a refilling feed drops ready and sets bit2. Neither error flag is ever high together with ready.
- R8: An empty hopper seen in the ready state drops ready and keeps the card (5'b10000). Start then gives 5'b10011. The next feed delivers the held card with no `phys_feed` pulse and ends with `status` all zero.
- R9: Runout, in the idle or error state, clears both error flags and the station. The next start runs in a fresh card.
- R10: `sense_req` loads `sense_word` with that cycle's `status`, visible one cycle later. Otherwise `sense_word` holds its value.
- R11: `host_rd` outside a feed cycle is ignored. No column is consumed and `host_col_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_start | input | 1 | Operator start button, one-cycle pulse |
| btn_npro | input | 1 | Operator runout button, one-cycle pulse |
| hopper_empty | input | 1 | Physical hopper has no cards |
| phys_feed | output | 1 | One-cycle request for a physical card feed |
| phys_col_valid | input | 1 | Column strobe from the physical reader |
| phys_col | input | ROWS | Punch rows of the strobed column |
| phys_read_chk | input | 1 | Physical read check |
| phys_feed_chk | input | 1 | Physical feed check |
| host_feed | input | 1 | Host feed-cycle request |
| host_rd | input | 1 | Host pops one column |
| host_col | output | ROWS | Column at the head of the station |
| host_col_valid | output | 1 | A column is available to the host |
| sense_req | input | 1 | Host sense-device request |
| sense_word | output | 5 | Status captured by the last sense request |
| status | output | 5 | Live status flags |

## Verification
Responses from the control path land one cycle after the stimulus edge. That covers `phys_feed` after start or feed, the error state after a rejected feed, and the ready drop after the hopper empties. `sense_word` likewise trails its request by one cycle. The last captured column passes through a done register before the sample point, so status settles two to three cycles after the final column strobe. The bench waits a fixed four cycles before comparing, and adds the remaining padding cycles after a read check. `host_col` shows the station head with no delay, so every popped column is compared against the reference queue on the falling edge before its pop.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

  localparam int STAT_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN_IN,
    ST_READY,
    ST_FEEDING,
    ST_LAST,
    ST_ERROR
  } cfb_state_e;

  // bit4 station full, bit3 read check, bit2 feed check, bit1 last card, bit0 ready
  typedef struct packed {
    logic pfull;
    logic rchk;
    logic fchk;
    logic lastc;
    logic ready;
  } cfb_status_t;

endpackage

// File: rtl/cfb_column_fifo.sv
module cfb_column_fifo #(
  parameter int DEPTH = 160,
  parameter int W     = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         rd,
  input  logic         flush,
  output logic [W-1:0] rdata
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;

  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    if (flush) begin
      wp_d = '0;
      rp_d = '0;
    end else begin
      if (wr) wp_d = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (rd) rp_d = (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr && !flush) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];

endmodule

// File: rtl/cfb_capture.sv
module cfb_capture #(
  parameter int COLS = 80,
  parameter int ROWS = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            collecting,
  input  logic            col_valid,
  input  logic [ROWS-1:0] col_data,
  input  logic            read_chk,
  output logic            wr_en,
  output logic [ROWS-1:0] wr_data,
  output logic            done,
  output logic            bad
);
  localparam int CW = $clog2(COLS + 1);

  logic          busy_q, busy_d;
  logic          pad_q, pad_d;
  logic          done_q, done_d;
  logic          bad_q, bad_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign wr_en   = busy_q & collecting & (pad_q | col_valid);
  assign wr_data = pad_q ? '0 : col_data;
  assign done    = done_q;
  assign bad     = bad_q;

  always_comb begin
    busy_d = busy_q;
    pad_d  = pad_q;
    cnt_d  = cnt_q;
    bad_d  = bad_q;
    done_d = 1'b0;
    if (!collecting) begin
      busy_d = 1'b0;
      pad_d  = 1'b0;
    end else if (arm) begin
      busy_d = 1'b1;
      pad_d  = 1'b0;
      cnt_d  = '0;
      bad_d  = 1'b0;
    end else if (busy_q) begin
      if (wr_en) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CW'(COLS-1)) begin
          busy_d = 1'b0;
          pad_d  = 1'b0;
          done_d = 1'b1;
        end
      end
      if (read_chk && !pad_q && busy_d) begin
        pad_d = 1'b1;
        bad_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pad_q  <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      pad_q  <= pad_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      bad_q  <= bad_d;
    end
  end

endmodule

// File: rtl/cfb_seq.sv
module cfb_seq import cfb_pkg::*; #(
  parameter int COLS = 80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        btn_start,
  input  logic        btn_npro,
  input  logic        hopper_empty,
  input  logic        host_feed,
  input  logic        host_rd,
  input  logic        feed_chk,
  input  logic        cap_done,
  input  logic        cap_bad,
  output logic        phys_feed,
  output logic        collecting,
  output logic        flush,
  output logic        pop,
  output logic        col_valid,
  output cfb_status_t stat
);
  localparam int CW = $clog2(COLS + 1);

  cfb_state_e    st_q, st_d;
  logic          fchk_q, fchk_d, rchk_q, rchk_d;
  logic          lastc_q, lastc_d, pfull_q, pfull_d;
  logic          pend_q, pend_d, refill_q, refill_d;
  logic          got_q, got_d, feed_q, feed_d;
  logic [CW-1:0] dcnt_q, dcnt_d;

  assign col_valid  = (st_q == ST_FEEDING) && (dcnt_q < CW'(COLS));
  assign pop        = col_valid && host_rd;
  assign collecting = (st_q == ST_RUN_IN) || (st_q == ST_FEEDING);
  assign flush      = btn_npro && ((st_q == ST_IDLE) || (st_q == ST_ERROR));
  assign phys_feed  = feed_q;

  always_comb begin
    stat.pfull = pfull_q;
    stat.rchk  = rchk_q;
    stat.fchk  = fchk_q;
    stat.lastc = lastc_q;
    stat.ready = (st_q == ST_READY) || (st_q == ST_LAST);
  end

  always_comb begin
    st_d     = st_q;
    fchk_d   = fchk_q;
    rchk_d   = rchk_q;
    lastc_d  = lastc_q;
    pfull_d  = pfull_q;
    pend_d   = pend_q;
    refill_d = refill_q;
    dcnt_d   = dcnt_q;
    feed_d   = 1'b0;
    got_d    = got_q | cap_done;
    unique case (st_q)
      ST_IDLE: begin
        if (flush) begin
          fchk_d  = 1'b0;
          rchk_d  = 1'b0;
          lastc_d = 1'b0;
          pfull_d = 1'b0;
          pend_d  = 1'b0;
        end else if (btn_start) begin
          if (pfull_q && hopper_empty) begin
            st_d    = ST_LAST;
            lastc_d = 1'b1;
          end else if (pfull_q) begin
            st_d = ST_READY;
          end else if (!hopper_empty) begin
            st_d   = ST_RUN_IN;
            feed_d = 1'b1;
          end
        end
      end
      ST_RUN_IN: begin
        if (feed_chk) begin
          st_d   = ST_ERROR;
          fchk_d = 1'b1;
        end else if (cap_done) begin
          st_d    = ST_READY;
          pfull_d = 1'b1;
          pend_d  = cap_bad;
        end
      end
      ST_READY, ST_LAST: begin
        if (st_q == ST_READY && hopper_empty) begin
          st_d = ST_IDLE;
        end else if (host_feed) begin
          if (pend_q) begin
            st_d   = ST_ERROR;
            rchk_d = 1'b1;
          end else begin
            st_d     = ST_FEEDING;
            dcnt_d   = '0;
            got_d    = 1'b0;
            refill_d = (st_q == ST_READY);
            feed_d   = (st_q == ST_READY);
          end
        end
      end
      ST_FEEDING: begin
        if (pop) dcnt_d = dcnt_q + 1'b1;
        if (refill_q && feed_chk) begin
          st_d   = ST_ERROR;
          fchk_d = 1'b1;
        end else if (dcnt_q == CW'(COLS) && (!refill_q || got_q)) begin
          if (refill_q) begin
            st_d    = ST_READY;
            pfull_d = 1'b1;
            pend_d  = cap_bad;
          end else begin
            st_d    = ST_IDLE;
            pfull_d = 1'b0;
            lastc_d = 1'b0;
          end
        end
      end
      ST_ERROR: begin
        if (flush) begin
          st_d    = ST_IDLE;
          fchk_d  = 1'b0;
          rchk_d  = 1'b0;
          lastc_d = 1'b0;
          pfull_d = 1'b0;
          pend_d  = 1'b0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      fchk_q   <= 1'b0;
      rchk_q   <= 1'b0;
      lastc_q  <= 1'b0;
      pfull_q  <= 1'b0;
      pend_q   <= 1'b0;
      refill_q <= 1'b0;
      got_q    <= 1'b0;
      feed_q   <= 1'b0;
      dcnt_q   <= '0;
    end else begin
      st_q     <= st_d;
      fchk_q   <= fchk_d;
      rchk_q   <= rchk_d;
      lastc_q  <= lastc_d;
      pfull_q  <= pfull_d;
      pend_q   <= pend_d;
      refill_q <= refill_d;
      got_q    <= got_d;
      feed_q   <= feed_d;
      dcnt_q   <= dcnt_d;
    end
  end

endmodule

// File: rtl/card_feed_buffer.sv
module card_feed_buffer import cfb_pkg::*; #(
  parameter int COLS = 80,
  parameter int ROWS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              btn_start,
  input  logic              btn_npro,
  input  logic              hopper_empty,
  output logic              phys_feed,
  input  logic              phys_col_valid,
  input  logic [ROWS-1:0]   phys_col,
  input  logic              phys_read_chk,
  input  logic              phys_feed_chk,
  input  logic              host_feed,
  input  logic              host_rd,
  output logic [ROWS-1:0]   host_col,
  output logic              host_col_valid,
  input  logic              sense_req,
  output logic [STAT_W-1:0] sense_word,
  output logic [STAT_W-1:0] status
);
  localparam int DEPTH = 2 * COLS;

  logic            cap_wr, cap_done, cap_bad;
  logic [ROWS-1:0] cap_data;
  logic            collecting, flush, pop;
  cfb_status_t     stat;
  logic [STAT_W-1:0] sense_q, sense_d;

  cfb_seq #(.COLS(COLS)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .btn_start    (btn_start),
    .btn_npro     (btn_npro),
    .hopper_empty (hopper_empty),
    .host_feed    (host_feed),
    .host_rd      (host_rd),
    .feed_chk     (phys_feed_chk),
    .cap_done     (cap_done),
    .cap_bad      (cap_bad),
    .phys_feed    (phys_feed),
    .collecting   (collecting),
    .flush        (flush),
    .pop          (pop),
    .col_valid    (host_col_valid),
    .stat         (stat)
  );

  cfb_capture #(.COLS(COLS), .ROWS(ROWS)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (phys_feed),
    .collecting (collecting),
    .col_valid  (phys_col_valid),
    .col_data   (phys_col),
    .read_chk   (phys_read_chk),
    .wr_en      (cap_wr),
    .wr_data    (cap_data),
    .done       (cap_done),
    .bad        (cap_bad)
  );

  cfb_column_fifo #(.DEPTH(DEPTH), .W(ROWS)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cap_wr),
    .wdata (cap_data),
    .rd    (pop),
    .flush (flush),
    .rdata (host_col)
  );

  assign status = stat;

  always_comb begin
    sense_d = sense_q;
    if (sense_req) sense_d = stat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sense_q <= '0;
    else        sense_q <= sense_d;
  end

  assign sense_word = sense_q;

endmodule

// File: rtl/card_feed_buffer_chk.sv
module card_feed_buffer_chk #(
  parameter int COLS = 80
) (
  input logic       clk,
  input logic       rst_n,
  input logic       phys_feed,
  input logic       host_feed,
  input logic       host_rd,
  input logic       host_col_valid,
  input logic       sense_req,
  input logic [4:0] sense_word,
  input logic [4:0] status
);
  localparam int PW = $clog2(COLS + 2);

  logic [PW-1:0] pops_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pops_q <= '0;
    else if (host_feed && status[0]) pops_q <= '0;
    else if (host_rd && host_col_valid) pops_q <= pops_q + 1'b1;
  end

  p_feed_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phys_feed |=> !phys_feed);

  p_pop_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pops_q <= PW'(COLS));

  p_pfull_in_feed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_col_valid |-> status[4]);

  p_err_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] || status[3]) |-> !status[0]);

  p_last_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> status[4]);

  p_last_no_feed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> !phys_feed);

  p_sense_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sense_req |=> (sense_word == $past(status)));

endmodule

bind card_feed_buffer card_feed_buffer_chk #(.COLS(COLS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .phys_feed      (phys_feed),
  .host_feed      (host_feed),
  .host_rd        (host_rd),
  .host_col_valid (host_col_valid),
  .sense_req      (sense_req),
  .sense_word     (sense_word),
  .status         (status)
);

// File: tb/card_feed_buffer_tb.sv
module card_feed_buffer_tb;
  localparam int COLS = 80;
  localparam int ROWS = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_start = 0, btn_npro = 0, hopper_empty = 0;
  logic phys_col_valid = 0, phys_read_chk = 0, phys_feed_chk = 0;
  logic [ROWS-1:0] phys_col = '0;
  logic host_feed = 0, host_rd = 0, sense_req = 0;
  logic phys_feed, host_col_valid;
  logic [ROWS-1:0] host_col;
  logic [4:0] sense_word, status;

  int nchk = 0;
  int nfail = 0;
  int nfeeds = 0;
  logic [ROWS-1:0] expq [$];

  always #5 clk = ~clk;

  card_feed_buffer #(.COLS(COLS), .ROWS(ROWS)) u_dut (
    .clk(clk), .rst_n(rst_n), .btn_start(btn_start), .btn_npro(btn_npro),
    .hopper_empty(hopper_empty), .phys_feed(phys_feed),
    .phys_col_valid(phys_col_valid), .phys_col(phys_col),
    .phys_read_chk(phys_read_chk), .phys_feed_chk(phys_feed_chk),
    .host_feed(host_feed), .host_rd(host_rd), .host_col(host_col),
    .host_col_valid(host_col_valid), .sense_req(sense_req),
    .sense_word(sense_word), .status(status)
  );

  always @(posedge clk) if (phys_feed) nfeeds++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [ROWS-1:0] pat(input int card, input int i);
    return ROWS'((card << 8) | i);
  endfunction

  task automatic press_start();
    btn_start = 1; @(negedge clk); btn_start = 0;
  endtask

  task automatic press_npro();
    btn_npro = 1; @(negedge clk); btn_npro = 0;
    expq.delete();
  endtask

  // drives one physical card; err_at < 0 means no read check
  task automatic supply(input int card, input int err_at);
    @(negedge clk);
    for (int i = 0; i < COLS; i++) begin
      if (i == err_at) begin
        phys_col_valid = 0;
        phys_read_chk = 1;
        @(negedge clk);
        phys_read_chk = 0;
        for (int k = i; k < COLS; k++) expq.push_back('0);
        cyc(COLS - i + 2);
        return;
      end
      phys_col_valid = 1;
      phys_col = pat(card, i);
      expq.push_back(pat(card, i));
      @(negedge clk);
    end
    phys_col_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < COLS; i++) begin
      logic [ROWS-1:0] e;
      e = expq.pop_front();
      chk(host_col_valid == 1'b1, "R3 col valid", host_col_valid, 1);
      chk(host_col == e, "R3 column data", host_col, e);
      if (i == COLS / 2) chk(status[4] == 1'b1, "R5 station bit held", status[4], 1);
      host_rd = 1;
      @(negedge clk);
    end
    host_rd = 0;
    chk(host_col_valid == 1'b0, "R3 valid after 80", host_col_valid, 0);
  endtask

  task automatic do_feed(input bit refill, input int card, input int err_at);
    host_feed = 1; @(negedge clk); host_feed = 0;
    if (refill) begin
      chk(phys_feed == 1'b1, "R4 feed pulse", phys_feed, 1);
      fork
        drain();
        supply(card, err_at);
      join
    end else begin
      chk(phys_feed == 1'b0, "R8 no physical feed", phys_feed, 0);
      drain();
    end
    cyc(4);
  endtask

  task automatic finish_sim();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_sim();
  end

  initial begin
    int f0;
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    chk(status == 5'b0, "R1 status", status, 0);
    chk(sense_word == 5'b0, "R1 sense", sense_word, 0);
    chk(phys_feed == 1'b0, "R1 feed", phys_feed, 0);

    // R11 host read while idle
    host_rd = 1; cyc(2);
    chk(host_col_valid == 1'b0, "R11 idle valid", host_col_valid, 0);
    host_rd = 0;

    // R2 run-in
    f0 = nfeeds;
    press_start();
    chk(phys_feed == 1'b1, "R2 feed pulse", phys_feed, 1);
    supply(1, -1);
    cyc(4);
    chk(nfeeds - f0 == 1, "R2 single pulse", nfeeds - f0, 1);
    chk(status == 5'b10001, "R2 ready after run-in", status, 5'b10001);

    // R10 sense
    sense_req = 1; @(negedge clk); sense_req = 0;
    chk(sense_word == 5'b10001, "R10 sense ready", sense_word, 5'b10001);

    // R11 reads in ready state are ignored
    host_rd = 1; cyc(3); host_rd = 0;
    chk(host_col_valid == 1'b0, "R11 ready valid", host_col_valid, 0);

    // R3 R4 R5 normal feed
    do_feed(1, 2, -1);
    chk(status == 5'b10001, "R4 ready after feed", status, 5'b10001);

    // R6 card 3 short: read check after 30 columns, deferred
    do_feed(1, 3, 30);
    chk(status == 5'b10001, "R6 still ready", status, 5'b10001);
    f0 = nfeeds;
    host_feed = 1; @(negedge clk); host_feed = 0;
    chk(status == 5'b11000, "R6 read check reported", status, 5'b11000);
    cyc(2);
    chk(nfeeds == f0, "R6 no feed on error", nfeeds, f0);
    sense_req = 1; @(negedge clk); sense_req = 0;
    chk(sense_word == 5'b11000, "R10 sense error", sense_word, 5'b11000);
    cyc(3);
    chk(sense_word == 5'b11000, "R10 sense holds", sense_word, 5'b11000);

    // R9 runout
    press_npro();
    chk(status == 5'b0, "R9 cleared", status, 0);

    // R7 feed check during run-in
    press_start();
    chk(phys_feed == 1'b1, "R7 run-in pulse", phys_feed, 1);
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      phys_col_valid = 1; phys_col = pat(4, i); @(negedge clk);
    end
    phys_col_valid = 0;
    phys_feed_chk = 1; @(negedge clk); phys_feed_chk = 0;
    chk(status == 5'b00100, "R7 feed check", status, 5'b00100);
    press_npro();
    chk(status == 5'b0, "R9 cleared again", status, 0);

    // R9 fresh run-in, then R8 hopper runs dry
    press_start();
    supply(5, -1);
    cyc(4);
    chk(status == 5'b10001, "R9 fresh card ready", status, 5'b10001);
    hopper_empty = 1; cyc(2);
    chk(status == 5'b10000, "R8 ready drop", status, 5'b10000);
    press_start();
    chk(status == 5'b10011, "R8 last card", status, 5'b10011);
    f0 = nfeeds;
    do_feed(0, 0, -1);
    chk(status == 5'b0, "R8 after last card", status, 0);
    chk(nfeeds == f0, "R8 no pulses", nfeeds, f0);

    finish_sim();
  end

endmodule